// File: doc/BRIEF.md
# SPI Master with Transmit and Receive Byte Queues

This block is an SPI master controlled through a small register port. Software pushes bytes into a 16-entry transmit queue. Whenever shifting is enabled, the block takes bytes from that queue one at a time and shifts each out on MOSI, most significant bit first, in SPI mode 0. It captures the byte that arrives on MISO at the same time and places it in a 16-entry receive queue. If the discard option is set, received bytes are dropped instead of stored.

The SCK rate comes from a half-period divider register. A two-bit select field drives at most one of three active-low slave-select lines. A status word reports the busy state and the level flags of both queues, and two separate registers report how many entries each queue holds. Both queues can be emptied by writing self-clearing clear bits in the control register.

Top module: `spi_fifo_master`

## Requirements
- R1: The control select field is bits [1:0]. Value 0 drives all three `ss_n` lines high. Values 1, 2 and 3 drive `ss_n[0]`, `ss_n[1]` and `ss_n[2]` low respectively, and never more than one line is low.
- R2: The divider register (address 1) holds N. While a byte is shifting, each high level and each low level of SCK lasts exactly N+1 clock cycles.
- R3: SPI mode 0, MSB first. SCK is low whenever no byte is shifting. MOSI changes only while SCK is low. MISO is sampled when SCK rises, so the received byte holds the eight samples in order, first sample in bit 7.
- R4: Shifting happens only while the enable bit (control bit 2) is set. While it is clear, SCK holds its level and the transmit queue is not popped.
- R5: While the discard bit (control bit 3) is set, completed bytes are not pushed into the receive queue.
- R6: Writing the control register with bit 4 set empties the transmit queue. Writing it with bit 5 set empties the receive queue. Both bits read back as 0.
- R7: A read of address 0 returns busy in bit 15, RX not-empty in bit 14, RX half-full in bit 13, RX full in bit 12, TX empty in bit 11, TX half-empty in bit 10 and TX not-full in bit 9. Bits [3:0] read back the discard, enable and select settings, and bits 8..4 read 0.
- R8: A write to the data register (address 4) pushes bits [7:0] into the transmit queue. A write to a full queue is ignored. A read strobe at address 4 returns the oldest received byte and pops it.
- R9: Address 2 reads the transmit queue occupancy and address 3 reads the receive queue occupancy, each in bits [7:0].
- R10: Busy is 1 while the transmit queue is non-empty or a byte is shifting. It falls only after the last bit of the final byte has been sampled and stored.
- R11: Each queue holds 16 bytes. Half-full means an occupancy of at least 8, and half-empty means an occupancy of at most 8. A byte that completes while the receive queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at the data address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 3 | Active-low slave selects |

## Verification
On every cycle the assertions check the following: at most one slave select is active, MOSI is steady while SCK is high, SCK rests low when idle and is frozen while shifting is disabled, busy covers any shift in progress, and the level flags agree with one another. Only the bench's scenarios can show the rest: the exact divider period, the bit order seen by a mode-0 slave model, the queue thresholds and overflow behaviour, the effect of discard and the clear bits, and that received data is present once busy falls.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_DIV   = 3'd1;
  localparam logic [2:0] ADDR_TXCNT = 3'd2;
  localparam logic [2:0] ADDR_RXCNT = 3'd3;
  localparam logic [2:0] ADDR_DATA  = 3'd4;

  // Encoded select to active-low one-cold lines.
  function automatic logic [2:0] sel_to_ss_n(input logic [1:0] sel);
    logic [2:0] v;
    v = 3'b111;
    if (sel != 2'd0) v[sel - 2'd1] = 1'b0;
    return v;
  endfunction

  // Level thresholds for a queue of a given depth.
  function automatic logic is_half_full(input int unsigned cnt, input int unsigned depth);
    return cnt >= depth / 2;
  endfunction

  function automatic logic is_half_empty(input int unsigned cnt, input int unsigned depth);
    return cnt <= depth / 2;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_fifo_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          half_full,
  output logic          half_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign half_full  = is_half_full(int'(count), DEPTH);
  assign half_empty = is_half_empty(int'(count), DEPTH);
  assign push_ok    = push && !full;
  assign pop_ok     = pop && !empty;
  assign dout       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_avail,
  input  logic [7:0]       tx_byte,
  output logic             tx_take,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [7:0]       rx_byte,
  output logic             rx_done,
  output logic             active
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       tx_sh, rx_sh;
  logic             half_tick, rise_ev, fall_ev;

  assign tx_take   = !active && enable && tx_avail;
  assign half_tick = active && enable && (cnt == div);
  assign rise_ev   = half_tick && !sck;
  assign fall_ev   = half_tick && sck;
  assign rx_done   = fall_ev && (bit_idx == 3'd7);
  assign mosi      = tx_sh[7];
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (tx_take) begin
      active  <= 1'b1;
      sck     <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      tx_sh   <= tx_byte;
    end else if (active && enable) begin
      if (half_tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
      if (rise_ev) begin
        sck   <= 1'b1;
        rx_sh <= {rx_sh[6:0], miso};
      end
      if (fall_ev) begin
        sck <= 1'b0;
        if (bit_idx == 3'd7) begin
          active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sh   <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  ss_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]       sel_q;
  logic             en_q, discard_q;
  logic [DIV_W-1:0] div_q;

  // Named events.
  logic ctrl_wr_ev, tx_clr_ev, rx_clr_ev, tx_push_ev, rx_pop_ev, rx_push_ev, tx_take_ev;
  logic shift_active, busy, byte_done;
  logic [7:0] tx_head, rx_head, rx_captured;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, tx_hf, tx_he;
  logic rx_full, rx_empty, rx_hf, rx_he;
  logic [15:0] status_word;

  assign ctrl_wr_ev = reg_wr && (reg_addr == ADDR_CTRL);
  assign tx_clr_ev  = ctrl_wr_ev && reg_wdata[4];
  assign rx_clr_ev  = ctrl_wr_ev && reg_wdata[5];
  assign tx_push_ev = reg_wr && (reg_addr == ADDR_DATA);
  assign rx_pop_ev  = reg_rd && (reg_addr == ADDR_DATA);
  assign rx_push_ev = byte_done && !discard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      en_q      <= 1'b0;
      discard_q <= 1'b0;
      div_q     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) begin
        sel_q     <= reg_wdata[1:0];
        en_q      <= reg_wdata[2];
        discard_q <= reg_wdata[3];
      end
      if (reg_addr == ADDR_DIV) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr_ev),
    .push(tx_push_ev), .din(reg_wdata[7:0]),
    .pop(tx_take_ev), .dout(tx_head), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty), .half_full(tx_hf), .half_empty(tx_he)
  );

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr_ev),
    .push(rx_push_ev), .din(rx_captured),
    .pop(rx_pop_ev), .dout(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty), .half_full(rx_hf), .half_empty(rx_he)
  );

  spi_shift_engine #(.DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .div(div_q),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_take(tx_take_ev),
    .miso(miso), .sck(sck), .mosi(mosi),
    .rx_byte(rx_captured), .rx_done(byte_done), .active(shift_active)
  );

  assign busy = shift_active || !tx_empty;
  assign ss_n = sel_to_ss_n(sel_q);

  assign status_word = {busy, !rx_empty, rx_hf, rx_full, tx_empty, tx_he, !tx_full,
                        5'b0, discard_q, en_q, sel_q};

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:  reg_rdata = status_word;
      ADDR_DIV:   reg_rdata = 16'(div_q);
      ADDR_TXCNT: reg_rdata = 16'(tx_cnt);
      ADDR_RXCNT: reg_rdata = 16'(rx_cnt);
      ADDR_DATA:  reg_rdata = rx_empty ? 16'h0 : {8'h0, rx_head};
      default:    reg_rdata = 16'h0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic        mosi,
  input logic [2:0]  ss_n,
  input logic        en_q,
  input logic        shift_active,
  input logic [15:0] status_word
);
  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_active |-> !sck);

  a_r4_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(sck));

  a_r10_busy_covers_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_active |-> status_word[15]);

  a_r10_busy_fall_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_word[15]) |-> !sck);

  a_r11_rx_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[12] |-> (status_word[13] && status_word[14]));

  a_r11_tx_empty_levels: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[11] |-> (status_word[10] && status_word[9]));
endmodule

bind spi_fifo_master spi_fifo_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
  .en_q(en_q), .shift_active(shift_active), .status_word(status_word)
);

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck, mosi, miso;
  logic [2:0]  ss_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // Mode-0 slave model: replies with a known byte sequence.
  function automatic logic [7:0] reply(input int k);
    return 8'h5A ^ 8'(k * 29);
  endfunction

  int         s_bits = 0, s_bytes = 0;
  logic [7:0] s_sh = '0, s_last = '0, s_cur;

  initial begin
    s_cur = reply(0);
    miso  = s_cur[7];
  end

  always @(posedge sck) begin
    s_sh   = {s_sh[6:0], mosi};
    s_bits = s_bits + 1;
    if (s_bits == 8) s_last = s_sh;
  end

  always @(negedge sck) begin
    if (s_bits == 8) begin
      s_bits  = 0;
      s_bytes = s_bytes + 1;
      s_cur   = reply(s_bytes);
      miso    = s_cur[7];
    end else begin
      miso = s_cur[7 - s_bits];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input bit pop, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    if (pop) begin
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
    end
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    int n = 0;
    do begin
      rd(3'd0, 1'b0, st);
      n++;
    end while (st[15] && n < 20000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, 1'b0, d);
    check("R7 reset status", d, 16'h0E00);
    rd(3'd2, 1'b0, d); check("R9 reset tx count", d, 0);
    rd(3'd3, 1'b0, d); check("R9 reset rx count", d, 0);
    check("R1 reset selects", ss_n, 3'b111);
    check("R3 reset sck", sck, 1'b0);
  endtask

  task automatic t_select();
    logic [2:0] exp [4] = '{3'b111, 3'b110, 3'b101, 3'b011};
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 16'(s));
      #1 check("R1 select decode", ss_n, exp[s]);
    end
  endtask

  task automatic t_transfer();
    logic [15:0] d;
    int n;
    int k0 = s_bytes;
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0005);
    wr(3'd4, 16'h00A5);
    wait (sck == 1'b1);
    n = 0;
    while (sck) begin @(posedge clk); #1; n++; end
    check("R2 sck high cycles", n, 4);
    n = 0;
    while (!sck) begin @(posedge clk); #1; n++; end
    check("R2 sck low cycles", n, 4);
    wait_idle();
    rd(3'd3, 1'b0, d);
    check("R10 rx stored when busy falls", d, 1);
    check("R3 slave got MSB-first byte", s_last, 8'hA5);
    rd(3'd4, 1'b1, d);
    check("R8 R3 received byte", d, reply(k0));
    rd(3'd3, 1'b0, d);
    check("R8 pop lowers rx count", d, 0);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    int b0;
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h003C);
    b0 = s_bytes;
    repeat (60) @(posedge clk);
    #1 check("R4 sck held when disabled", sck, 1'b0);
    rd(3'd2, 1'b0, d); check("R4 tx not popped", d, 1);
    rd(3'd0, 1'b0, d); check("R10 busy with queued byte", d[15], 1'b1);
    wr(3'd0, 16'h0005);
    wait_idle();
    check("R4 byte sent after enable", s_last, 8'h3C);
    check("R4 one byte shifted", s_bytes, b0 + 1);
    rd(3'd4, 1'b1, d);
  endtask

  task automatic t_discard();
    logic [15:0] d;
    wr(3'd0, 16'h000D);
    wr(3'd4, 16'h0011);
    wr(3'd4, 16'h0022);
    wait_idle();
    rd(3'd3, 1'b0, d); check("R5 discard keeps rx empty", d, 0);
    rd(3'd0, 1'b0, d); check("R5 rx not-empty clear", d[14], 1'b0);
    check("R5 bytes still shifted", s_last, 8'h22);
  endtask

  task automatic t_tx_levels();
    logic [15:0] d;
    wr(3'd0, 16'h0000);
    for (int i = 0; i < 17; i++) begin
      wr(3'd4, 16'(i));
      if (i == 7) begin
        rd(3'd0, 1'b0, d);
        check("R11 tx at 8 half-empty", d[10], 1'b1);
      end
      if (i == 8) begin
        rd(3'd0, 1'b0, d);
        check("R11 tx at 9 not half-empty", d[10], 1'b0);
      end
    end
    rd(3'd2, 1'b0, d); check("R8 R11 overflow write ignored", d, 16);
    rd(3'd0, 1'b0, d); check("R7 tx full status", d[11:9], 3'b000);
    wr(3'd0, 16'h0010);
    rd(3'd2, 1'b0, d); check("R6 tx clear", d, 0);
    rd(3'd0, 1'b0, d); check("R6 clear bit reads 0", d[8:0], 9'h000);
  endtask

  task automatic t_rx_levels();
    logic [15:0] d;
    int k0;
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0005);
    k0 = s_bytes;
    for (int i = 0; i < 17; i++) wr(3'd4, 16'(8'h80 + i));
    wait_idle();
    rd(3'd3, 1'b0, d); check("R11 rx full count", d, 16);
    rd(3'd0, 1'b0, d); check("R7 rx full flags", d[14:12], 3'b111);
    for (int i = 0; i < 16; i++) begin
      rd(3'd4, 1'b1, d);
      if (i == 0 || i == 15) check("R11 rx order, overflow dropped", d, reply(k0 + i));
      if (i == 8) begin
        rd(3'd0, 1'b0, d);
        check("R11 rx at 7 not half-full", d[13], 1'b0);
      end
    end
    rd(3'd0, 1'b0, d); check("R7 rx empty flag", d[14], 1'b0);
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0002);
    wait_idle();
    rd(3'd3, 1'b0, d); check("R9 rx count two", d, 2);
    wr(3'd0, 16'h0025);
    rd(3'd3, 1'b0, d); check("R6 rx clear", d, 0);
    rd(3'd0, 1'b0, d); check("R6 rx clear bit reads 0", d[5:4], 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_select();
    t_transfer();
    t_enable();
    t_discard();
    t_tx_levels();
    t_rx_levels();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule